// File: doc/BRIEF.md
# Transmit Status and Interrupt Identification

This block keeps track of the transmit side of a serial port controller. It follows how many characters wait in the transmit holding stage, which is a single holding register or a 16-entry queue depending on a mode input. It also follows whether the shift register that drives the line is still sending. From that it produces two status bits: holding-stage empty and transmitter fully empty. Only occupancy is tracked here; the character data and the serializer sit outside the block.

The block also merges three interrupt sources into one interrupt line and a 3-bit identification code. The sources, highest priority first, are a receiver line-status condition, received data available, and holding-stage empty. The holding-empty source is edge-armed. Once the CPU reads the identification code while that source is the one reported, it stays quiet until the holding stage empties again or its enable is switched back on.

Top module: `txirq_top`

## Requirements
- R1: After reset `thre` and `temt` are 1, `irq` is 0 and `iid` is 3'b001.
- R2: With `fifo_mode` = 0 the holding stage holds one character. A `thr_wr` clears `thre` in the cycle after the strobe. A second write while it is occupied is discarded. A `ser_load` that takes the character sets `thre` again.
- R3: With `fifo_mode` = 1 the holding stage holds 16 characters, and writes made while it holds 16 are discarded. `thre` is 1 only while the count is zero.
- R4: `temt` is 1 only when the holding stage is empty and the shift register is idle. An accepted `ser_load` marks the shift register busy. `shift_done` marks it idle unless a load is accepted in the same cycle.
- R5: `lsr_rd` has no effect on `thre` or `temt`.
- R6: `iid` reports the highest enabled request. A line-status request reports 3'b110, data-available 3'b100, holding-empty 3'b010, and nothing pending 3'b001. `irq` is 1 exactly when bit 0 of `iid` is 0. A request whose enable is 0 is ignored.
- R7: The holding-empty interrupt arms one cycle after `thre` goes from 0 to 1, or in the cycle its enable goes from 0 to 1 while `thre` is 1.
- R8: An `iir_rd` clears the armed holding-empty interrupt only when `iid` is 3'b010 at that clock edge. It does not re-arm until an R7 event.
- R9: A change of `fifo_mode` empties the holding stage.
- R10: A `ser_load` while the holding stage is empty is ignored and does not make the shift register busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_mode | input | 1 | 1 selects the 16-entry queue, 0 the single holding register |
| thr_wr | input | 1 | CPU write strobe into the holding stage |
| ser_load | input | 1 | Serializer takes one character into the shift register |
| shift_done | input | 1 | Last bit of the current character has left the shift register |
| lsr_rd | input | 1 | CPU read strobe of the line status register |
| iir_rd | input | 1 | CPU read strobe of the identification register |
| ier_rls_en | input | 1 | Enable for the line-status interrupt |
| ier_rda_en | input | 1 | Enable for the data-available interrupt |
| ier_thre_en | input | 1 | Enable for the holding-empty interrupt |
| rls_req | input | 1 | Line-status condition present |
| rda_req | input | 1 | Received data available |
| thre | output | 1 | Holding stage empty |
| temt | output | 1 | Holding stage and shift register both empty |
| irq | output | 1 | Interrupt line |
| iid | output | 3 | Identification code of the reported source |

## Verification
The checker watches on every cycle the relationships that hold locally. These are that `irq` matches bit 0 of `iid` and that a live line-status request always wins. They also cover that a status-register read leaves `thre` and `temt` alone, that an accepted write or load moves the status bits the next cycle, and that an acknowledge removes the holding-empty code. Queue capacity cannot be seen from a single cycle, and the bench's scenarios must show it. This covers overflow discard in both modes, the mode-change flush, priority changes as requests come and go, and re-arming only on a fresh empty edge.

// File: rtl/txirq_pkg.sv
package txirq_pkg;

   typedef enum logic [2:0] {
      IID_NONE = 3'b001,
      IID_RLS  = 3'b110,
      IID_RDA  = 3'b100,
      IID_THRE = 3'b010
   } iid_e;

   localparam int NUM_SRC = 3;

   // source index 0 is the highest priority
   function automatic iid_e src_code(input int idx);
      case (idx)
         0:       return IID_RLS;
         1:       return IID_RDA;
         2:       return IID_THRE;
         default: return IID_NONE;
      endcase
   endfunction

endpackage

// File: rtl/txirq_occ.sv
module txirq_occ #(
   parameter int DEPTH    = 16,
   parameter bit HAS_FIFO = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fifo_mode,
   input  logic wr,
   input  logic take,
   output logic take_ok,
   output logic empty
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cap;
   logic             mode_q;
   logic             wr_ok;
   logic             flush;

   generate
      if (HAS_FIFO) begin : g_queue
         assign cap = fifo_mode ? CNT_W'(DEPTH) : CNT_W'(1);
      end else begin : g_single
         assign cap = CNT_W'(1);
      end
   endgenerate

   assign flush   = (fifo_mode != mode_q);
   assign wr_ok   = wr && (cnt < cap);
   assign take_ok = take && (cnt != '0);
   assign empty   = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         mode_q <= 1'b0;
      end else begin
         mode_q <= fifo_mode;
         if (flush)
            cnt <= '0;
         else
            cnt <= cnt + CNT_W'(wr_ok) - CNT_W'(take_ok);
      end
   end

endmodule

// File: rtl/txirq_shift.sv
module txirq_shift (
   input  logic clk,
   input  logic rst_n,
   input  logic load_ok,
   input  logic done,
   output logic busy
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         busy <= 1'b0;
      else if (load_ok)
         busy <= 1'b1;
      else if (done)
         busy <= 1'b0;
   end
endmodule

// File: rtl/txirq_pend.sv
module txirq_pend (
   input  logic clk,
   input  logic rst_n,
   input  logic empty,
   input  logic en,
   input  logic ack,
   output logic req
);
   logic empty_q;
   logic en_q;
   logic pend;
   logic arm;

   // fresh empty edge, or enable switched on while empty
   assign arm = (empty && !empty_q) || (en && !en_q && empty);
   assign req = pend && empty && en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         empty_q <= 1'b1;
         en_q    <= 1'b0;
         pend    <= 1'b0;
      end else begin
         empty_q <= empty;
         en_q    <= en;
         if (arm)
            pend <= 1'b1;
         else if (ack)
            pend <= 1'b0;
      end
   end
endmodule

// File: rtl/txirq_prio.sv
module txirq_prio
   import txirq_pkg::*;
#(
   parameter int NSRC = NUM_SRC
) (
   input  logic [NSRC-1:0] req,
   output iid_e            iid,
   output logic            irq
);
   logic [NSRC:0]   blocked;
   logic [NSRC-1:0] win;

   generate
      if (NSRC != NUM_SRC) begin : g_bad_nsrc
         $error("txirq_prio: NSRC must match the code table size");
      end
   endgenerate

   assign blocked[0] = 1'b0;

   for (genvar i = 0; i < NSRC; i++) begin : g_chain
      assign win[i]         = req[i] && !blocked[i];
      assign blocked[i + 1] = blocked[i] || req[i];
   end

   always_comb begin
      iid = IID_NONE;
      for (int i = 0; i < NSRC; i++) begin
         if (win[i]) iid = src_code(i);
      end
   end

   assign irq = |req;

endmodule

// File: rtl/txirq_top.sv
module txirq_top
   import txirq_pkg::*;
#(
   parameter int DEPTH    = 16,
   parameter bit HAS_FIFO = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       fifo_mode,
   input  logic       thr_wr,
   input  logic       ser_load,
   input  logic       shift_done,
   input  logic       lsr_rd,
   input  logic       iir_rd,
   input  logic       ier_rls_en,
   input  logic       ier_rda_en,
   input  logic       ier_thre_en,
   input  logic       rls_req,
   input  logic       rda_req,
   output logic       thre,
   output logic       temt,
   output logic       irq,
   output logic [2:0] iid
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("txirq_top: DEPTH must be at least 2");
      end
   endgenerate

   logic                load_ok;
   logic                busy;
   logic                thre_req;
   logic                thre_ack;
   logic [NUM_SRC-1:0]  src_req;
   iid_e                iid_enc;

   txirq_occ #(.DEPTH(DEPTH), .HAS_FIFO(HAS_FIFO)) u_occ (
      .clk       (clk),
      .rst_n     (rst_n),
      .fifo_mode (fifo_mode),
      .wr        (thr_wr),
      .take      (ser_load),
      .take_ok   (load_ok),
      .empty     (thre)
   );

   txirq_shift u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_ok (load_ok),
      .done    (shift_done),
      .busy    (busy)
   );

   assign thre_ack = iir_rd && (iid_enc == IID_THRE);

   txirq_pend u_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .empty (thre),
      .en    (ier_thre_en),
      .ack   (thre_ack),
      .req   (thre_req)
   );

   assign src_req = {thre_req, rda_req && ier_rda_en, rls_req && ier_rls_en};

   txirq_prio #(.NSRC(NUM_SRC)) u_prio (
      .req (src_req),
      .iid (iid_enc),
      .irq (irq)
   );

   assign iid  = iid_enc;
   assign temt = thre && !busy;

endmodule

// File: rtl/txirq_chk.sv
module txirq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       fifo_mode,
   input logic       thr_wr,
   input logic       ser_load,
   input logic       shift_done,
   input logic       lsr_rd,
   input logic       iir_rd,
   input logic       ier_rls_en,
   input logic       ier_thre_en,
   input logic       rls_req,
   input logic       thre,
   input logic       temt,
   input logic       irq,
   input logic [2:0] iid
);
   logic thre_prev;
   logic en_prev;
   logic mode_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thre_prev <= 1'b1;
         en_prev   <= 1'b0;
         mode_prev <= 1'b0;
      end else begin
         thre_prev <= thre;
         en_prev   <= ier_thre_en;
         mode_prev <= fifo_mode;
      end
   end

   // R5
   lsr_noeffect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr_rd && !thr_wr && !ser_load && !shift_done && fifo_mode == mode_prev)
      |=> ($stable(thre) && $stable(temt)));

   // R4
   temt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (temt && !thr_wr) |=> temt);

   // R4
   temt_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_load && !thre) |=> !temt);

   // R2
   thre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_wr && !ser_load && fifo_mode == mode_prev) |=> !thre);

   // R6
   irq_iid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq == !iid[0]);

   // R6
   iid_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iid inside {3'b001, 3'b110, 3'b100, 3'b010});

   // R6
   rls_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rls_req && ier_rls_en) |-> iid == 3'b110);

   // R8
   ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iir_rd && iid == 3'b010 && thre_prev && en_prev) |=> iid != 3'b010);

   // R7
   arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (thre && !thre_prev && ier_thre_en) |=> (irq || !thre || !ier_thre_en));

endmodule

bind txirq_top txirq_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .fifo_mode   (fifo_mode),
   .thr_wr      (thr_wr),
   .ser_load    (ser_load),
   .shift_done  (shift_done),
   .lsr_rd      (lsr_rd),
   .iir_rd      (iir_rd),
   .ier_rls_en  (ier_rls_en),
   .ier_thre_en (ier_thre_en),
   .rls_req     (rls_req),
   .thre        (thre),
   .temt        (temt),
   .irq         (irq),
   .iid         (iid)
);

// File: tb/txirq_top_test.sv
module txirq_top_test;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fifo_mode = 1'b0, thr_wr = 1'b0, ser_load = 1'b0, shift_done = 1'b0;
   logic lsr_rd = 1'b0, iir_rd = 1'b0;
   logic ier_rls_en = 1'b0, ier_rda_en = 1'b0, ier_thre_en = 1'b0;
   logic rls_req = 1'b0, rda_req = 1'b0;
   logic thre, temt, irq;
   logic [2:0] iid;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      logic       thre;
      logic       temt;
      logic       irq;
      logic [2:0] iid;
      string      tag;
   } exp_t;

   exp_t q[$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   txirq_top uut (
      .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .thr_wr(thr_wr),
      .ser_load(ser_load), .shift_done(shift_done), .lsr_rd(lsr_rd),
      .iir_rd(iir_rd), .ier_rls_en(ier_rls_en), .ier_rda_en(ier_rda_en),
      .ier_thre_en(ier_thre_en), .rls_req(rls_req), .rda_req(rda_req),
      .thre(thre), .temt(temt), .irq(irq), .iid(iid)
   );

   // driver: one clock with the given strobes, expected outputs after the edge
   task automatic cyc(input logic wr, input logic ld, input logic dn,
                      input logic lr, input logic ir, input bit chk,
                      input logic et, input logic em, input logic ei,
                      input logic [2:0] eid, input string tag);
      exp_t e;
      @(negedge clk);
      thr_wr = wr; ser_load = ld; shift_done = dn; lsr_rd = lr; iir_rd = ir;
      if (chk) begin
         e.thre = et; e.temt = em; e.irq = ei; e.iid = eid; e.tag = tag;
         q.push_back(e);
      end
      @(posedge clk);
      #3;
   endtask

   // monitor: compares the front item just after the edge it belongs to
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (thre !== e.thre || temt !== e.temt || irq !== e.irq || iid !== e.iid) begin
               errors++;
               $display("FAIL %s: got thre=%b temt=%b irq=%b iid=%b, expected thre=%b temt=%b irq=%b iid=%b",
                        e.tag, thre, temt, irq, iid, e.thre, e.temt, e.irq, e.iid);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      cyc(0,0,0,0,0, 1, 1,1,0,3'b001, "R1 reset state");

      ier_thre_en = 1'b1;
      cyc(0,0,0,0,0, 1, 1,1,1,3'b010, "R7 enable rise while empty");
      cyc(0,0,0,0,1, 1, 1,1,0,3'b001, "R8 ack clears holding-empty");
      cyc(0,0,0,0,0, 1, 1,1,0,3'b001, "R8 no re-arm without event");

      cyc(1,0,0,0,0, 1, 0,0,0,3'b001, "R2 write clears thre");
      cyc(1,0,0,0,0, 1, 0,0,0,3'b001, "R2 second write discarded");
      cyc(0,1,0,0,0, 1, 1,0,0,3'b001, "R2 load empties holding register");
      cyc(0,0,0,0,0, 1, 1,0,1,3'b010, "R7 arm one cycle after empty edge");
      cyc(0,0,0,1,0, 1, 1,0,1,3'b010, "R5 status read while busy");
      cyc(0,0,1,0,0, 1, 1,1,1,3'b010, "R4 shift done sets temt");
      cyc(0,1,0,0,0, 1, 1,1,1,3'b010, "R10 load while empty ignored");
      cyc(0,0,0,1,0, 1, 1,1,1,3'b010, "R5 status read while empty");

      ier_rda_en = 1'b1; rda_req = 1'b1;
      cyc(0,0,0,0,0, 1, 1,1,1,3'b100, "R6 data-available over holding-empty");
      ier_rls_en = 1'b1; rls_req = 1'b1;
      cyc(0,0,0,0,1, 1, 1,1,1,3'b110, "R6 line-status highest");
      rls_req = 1'b0; rda_req = 1'b0;
      cyc(0,0,0,0,0, 1, 1,1,1,3'b010, "R8 read of other source keeps pending");
      ier_rls_en = 1'b0; rls_req = 1'b1;
      cyc(0,0,0,0,0, 1, 1,1,1,3'b010, "R6 disabled request ignored");
      rls_req = 1'b0;
      cyc(0,0,0,0,1, 1, 1,1,0,3'b001, "R8 ack when reported");

      ier_thre_en = 1'b0; ier_rda_en = 1'b0;
      fifo_mode = 1'b1;
      cyc(0,0,0,0,0, 1, 1,1,0,3'b001, "R9 mode switch to queue");
      for (int k = 0; k < 17; k++)
         cyc(1,0,0,0,0, 1, 0,0,0,3'b001, "R3 fill queue");
      for (int k = 0; k < 15; k++)
         cyc(0,1,0,0,0, 1, 0,0,0,3'b001, "R3 drain not yet empty");
      cyc(0,1,0,0,0, 1, 1,0,0,3'b001, "R3 empty after 16 loads");
      cyc(0,1,0,0,0, 1, 1,0,0,3'b001, "R10 extra load ignored");
      cyc(0,0,1,0,0, 1, 1,1,0,3'b001, "R4 temt after last shift");
      cyc(0,1,0,0,0, 1, 1,1,0,3'b001, "R10 load on empty keeps temt");

      cyc(1,0,0,0,0, 1, 0,0,0,3'b001, "R4 write clears temt");
      cyc(1,0,0,0,0, 1, 0,0,0,3'b001, "R3 second entry");
      cyc(0,1,0,0,0, 1, 0,0,0,3'b001, "R4 one left in queue");
      for (int k = 0; k < 3; k++)
         cyc(0,0,0,0,0, 1, 0,0,0,3'b001, "R4 temt held low while sending");
      cyc(0,1,1,0,0, 1, 1,0,0,3'b001, "R4 load with done keeps busy");
      cyc(0,0,0,0,0, 1, 1,0,0,3'b001, "R4 still sending");
      cyc(0,0,1,0,0, 1, 1,1,0,3'b001, "R4 done sets temt");

      for (int k = 0; k < 3; k++)
         cyc(1,0,0,0,0, 1, 0,0,0,3'b001, "R3 refill");
      fifo_mode = 1'b0;
      cyc(0,0,0,0,0, 1, 1,1,0,3'b001, "R9 mode change flushes queue");
      cyc(1,0,0,0,0, 1, 0,0,0,3'b001, "R9 holding mode after flush");
      cyc(1,0,0,0,0, 1, 0,0,0,3'b001, "R2 discard in holding mode");
      cyc(0,1,0,0,0, 1, 1,0,0,3'b001, "R2 single entry only");
      cyc(0,0,1,0,0, 1, 1,1,0,3'b001, "R4 final drain");

      cyc(0,0,0,0,0, 0, 0,0,0,3'b000, "idle");
      repeat (2) @(posedge clk);
      #5;
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule